// File: doc/BRIEF.md
# Receive Message Queue with Index Acknowledge

This block keeps received frames in a circular queue of fixed four-word elements (16 bytes each). A producer hands over one complete element per cycle through a valid/data port, and the block writes it at the current put index. Software consumes frames by reading the oldest element through a word-wide read port. To release it, software writes that element's index back. Every element up to and including the acknowledged one is freed in a single step, and the get index moves to the slot after it.

One 32-bit configuration word sets the queue length, the watermark and the base byte address of the element area. The queue length is at most 64 elements. A 32-bit status word reports the fill level, both indices, a full flag and a sticky lost-frame flag. The block also decodes the oldest element into its identifier, frame-type flags and length code, and gives that element's byte address. The queue always runs in blocking mode: a frame that arrives while the queue is full is thrown away and the loss is recorded. Three one-cycle event outputs report a new frame, the watermark being reached and a lost frame. The configuration word is only changed while reset is held.

Top module: `rx_elem_fifo`

## Requirements
- R1: After a synchronous active-low reset, the status word is zero, all three event outputs are low and `head_valid` is low.
- R2: When `wr_valid` is high, the effective length is nonzero and the queue is not full, the element is written at the put index. The put index then advances and wraps to 0 at the effective length, the fill level rises by one, and `evt_new` is high for exactly the cycle after that edge.
- R3: The status word holds the fill level in bits 6:0, the get index in bits 13:8, the put index in bits 21:16, the full flag in bit 24 and the lost flag in bit 25. All other bits read zero.
- R4: The full flag is set whenever the fill level equals a nonzero effective length. A frame offered while the queue is full is discarded: the put index and the stored contents stay unchanged, the lost flag is set, and `evt_lost` pulses for one cycle.
- R5: A `lost_clr` pulse clears the lost flag. If a frame is discarded in the same cycle, the flag stays set.
- R6: An acknowledge of an index that lies between the get index and the newest stored element frees every element from the get index through that index. The get index becomes that index plus one, modulo the effective length, and the fill level drops by the number of freed elements.
- R7: An acknowledge whose index is not below the effective length, or that lies outside the currently filled span, changes neither the indices nor the fill level.
- R8: `evt_wmark` pulses for one cycle when a store brings the fill level to a nonzero watermark. A watermark of 0 never pulses.
- R9: Configuration word fields: the queue length is bits 22:16, the watermark is bits 30:24 and the base byte address is bits 15:0. A length above 64 acts as 64. A length of 0 discards every frame without setting the lost flag. `head_addr` equals the base plus 16 times the get index.
- R10: For the oldest element, word 0 bit 31 gives `head_esi`, bit 30 gives `head_ext` and bit 29 gives `head_rtr`. `head_id` is word 0 bits 28:0 for an extended frame, and bits 28:18 right-aligned for a standard one. `head_dlc` is word 1 bits 19:16. `head_valid` is high when the fill level is nonzero.
- R11: `rd_data` returns word `rd_sel` of element `rd_idx`, combinationally. Word k occupies `wr_elem` bits 32k+31:32k.
- R12: A store and a valid acknowledge in the same cycle both take effect. Whether the store is accepted depends on the fill level before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Length, watermark and base address |
| wr_valid | input | 1 | Offer one element |
| wr_elem | input | 128 | Element, word 0 in the low bits |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 6 | Index being released |
| lost_clr | input | 1 | Clear the lost flag |
| rd_idx | input | 6 | Element to read |
| rd_sel | input | 2 | Word within element |
| rd_data | output | 32 | Selected word |
| status | output | 32 | Fill, indices, full, lost |
| head_valid | output | 1 | Queue holds at least one element |
| head_addr | output | 16 | Byte address of oldest element |
| head_id | output | 29 | Identifier of oldest element |
| head_ext | output | 1 | Oldest element uses an extended identifier |
| head_rtr | output | 1 | Oldest element is a remote frame |
| head_esi | output | 1 | Error-state flag of oldest element |
| head_dlc | output | 4 | Length code of oldest element |
| evt_new | output | 1 | Element stored |
| evt_wmark | output | 1 | Watermark reached |
| evt_lost | output | 1 | Element discarded |

## Verification
A wrong fill count or index shows up in the status word on the first sample after the faulty edge. It also shows up as a shifted `head_addr`. A premature or missing full flag makes a frame vanish or overwrite live data. The scoreboard catches that when the overwritten element is next read back, which is at the latest the next acknowledge that covers it. An acknowledge-range error either frees the wrong number of elements or moves the get index, and the first following status sample reveals it.

// File: rtl/rxq_pkg.sv
// Shared constants for the receive queue: status and configuration field
// positions and element word bit positions. Assumes at most 64 elements.
package rxq_pkg;
    localparam int ST_FILL_LSB = 0;
    localparam int ST_GET_LSB  = 8;
    localparam int ST_PUT_LSB  = 16;
    localparam int ST_FULL_BIT = 24;
    localparam int ST_LOST_BIT = 25;

    localparam int CF_BASE_LSB = 0;
    localparam int CF_BASE_W   = 16;
    localparam int CF_SIZE_LSB = 16;
    localparam int CF_WM_LSB   = 24;
    localparam int CF_FIELD_W  = 7;

    localparam int W0_ESI_BIT  = 31;
    localparam int W0_EXT_BIT  = 30;
    localparam int W0_RTR_BIT  = 29;
    localparam int W0_STD_LSB  = 18;
    localparam int STD_ID_W    = 11;
    localparam int EXT_ID_W    = 29;
    localparam int W1_DLC_LSB  = 16;
    localparam int DLC_W       = 4;
    localparam int WORD_W      = 32;
    localparam int ELEM_WORDS  = 4;
endpackage

// File: rtl/rxq_ctrl.sv
// Index and fill control of the receive queue. Decides per cycle whether an
// offered element is stored or dropped and whether an acknowledge is in range.
// Assumes size is stable outside reset and never exceeds 2**IDX_W.
module rxq_ctrl #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] size,
    input  logic             wr_valid,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic             lost_clr,
    output logic [IDX_W-1:0] put_idx,
    output logic [IDX_W-1:0] get_idx,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] fill_nxt,
    output logic             full,
    output logic             lost,
    output logic             store,
    output logic             drop
);
    // Distance from b forward to a on a ring of sz slots.
    function automatic logic [CNT_W-1:0] ring_dist(input logic [CNT_W-1:0] a,
                                                   input logic [CNT_W-1:0] b,
                                                   input logic [CNT_W-1:0] sz);
        if (a >= b) return a - b;
        return a + sz - b;
    endfunction

    // Slot following i on a ring of sz slots.
    function automatic logic [CNT_W-1:0] ring_next(input logic [CNT_W-1:0] i,
                                                   input logic [CNT_W-1:0] sz);
        if (i + 1'b1 == sz) return '0;
        return i + 1'b1;
    endfunction

    logic [CNT_W-1:0] put_x, get_x, ack_x, ack_off, freed, put_w, get_w;
    logic             ack_ok;

    assign put_x = CNT_W'(put_idx);
    assign get_x = CNT_W'(get_idx);
    assign ack_x = CNT_W'(ack_idx);
    assign full  = (size != '0) && (fill == size);

    // Classify this cycle's store and acknowledge against the pre-cycle fill.
    always_comb begin
        ack_off  = ring_dist(ack_x, get_x, size);
        ack_ok   = ack_valid && (ack_x < size) && (ack_off < fill);
        store    = wr_valid && (size != '0) && (fill < size);
        drop     = wr_valid && (size != '0) && (fill >= size);
        freed    = ack_ok ? ack_off + 1'b1 : '0;
        fill_nxt = fill - freed + CNT_W'(store);
        put_w    = ring_next(put_x, size);
        get_w    = ring_next(ack_x, size);
    end

    // Register indices, fill level and the sticky lost flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            put_idx <= '0;
            get_idx <= '0;
            fill    <= '0;
            lost    <= 1'b0;
        end else begin
            if (store)  put_idx <= put_w[IDX_W-1:0];
            if (ack_ok) get_idx <= get_w[IDX_W-1:0];
            fill <= fill_nxt;
            if (drop)          lost <= 1'b1;
            else if (lost_clr) lost <= 1'b0;
        end
    end

    AST_FILL_LE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= size);                                                   // R4
    AST_PUT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (size != '0) |-> (put_x < size));                                // R2
    AST_FILL_MATCHES_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> (fill == ring_dist(put_x, get_x, size)));              // R6
    AST_FULL_PTRS_MEET: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (put_idx == get_idx));                                  // R4
    AST_LOST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(wr_valid));                                // R4
endmodule

// File: rtl/rxq_store.sv
// Element storage: ELEM_WORDS lanes of DEPTH words, written together on store,
// with a combinational word read port and the first two words of the head slot.
module rxq_store #(
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    store,
    input  logic [IDX_W-1:0]        put_idx,
    input  logic [WORDS*WORD_W-1:0] elem,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [SEL_W-1:0]        rd_sel,
    input  logic [IDX_W-1:0]        head_idx,
    output logic [WORD_W-1:0]       rd_data,
    output logic [WORD_W-1:0]       head_w0,
    output logic [WORD_W-1:0]       head_w1
);
    logic [WORD_W-1:0] lane_rd [WORDS];
    logic [WORD_W-1:0] lane_hd [WORDS];

    for (genvar k = 0; k < WORDS; k++) begin : g_lane
        logic [WORD_W-1:0] mem [DEPTH];
        // Write word k of the accepted element into its lane.
        always_ff @(posedge clk) begin
            if (store) mem[put_idx] <= elem[k*WORD_W +: WORD_W];
        end
        assign lane_rd[k] = mem[rd_idx];
        assign lane_hd[k] = mem[head_idx];
    end

    assign rd_data = lane_rd[rd_sel];
    assign head_w0 = lane_hd[0];
    assign head_w1 = lane_hd[1];

    logic unused_hd;
    assign unused_hd = ^{lane_hd[2], lane_hd[3]};
endmodule

// File: rtl/rxq_events.sv
// One-cycle event pulses for stored, watermark-reached and discarded frames.
module rxq_events #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic             drop,
    input  logic [CNT_W-1:0] fill_nxt,
    input  logic [CNT_W-1:0] wmark,
    output logic             evt_new,
    output logic             evt_wmark,
    output logic             evt_lost
);
    // Register the pulses from this cycle's decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_new   <= 1'b0;
            evt_wmark <= 1'b0;
            evt_lost  <= 1'b0;
        end else begin
            evt_new   <= store;
            evt_lost  <= drop;
            evt_wmark <= store && (wmark != '0) && (fill_nxt == wmark);
        end
    end

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_new && evt_lost));                                         // R4
    AST_WMARK_NEEDS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wmark |-> evt_new);                                          // R8
endmodule

// File: rtl/rx_elem_fifo.sv
// Receive message queue top: decodes the configuration word, clamps the
// length to DEPTH, packs the status word and decodes the oldest element.
// Assumes cfg_word only changes while rst_n is low and DEPTH <= 64.
module rx_elem_fifo #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         cfg_word,
    input  logic                wr_valid,
    input  logic [127:0]        wr_elem,
    input  logic                ack_valid,
    input  logic [5:0]          ack_idx,
    input  logic                lost_clr,
    input  logic [5:0]          rd_idx,
    input  logic [1:0]          rd_sel,
    output logic [31:0]         rd_data,
    output logic [31:0]         status,
    output logic                head_valid,
    output logic [ADDR_W-1:0]   head_addr,
    output logic [28:0]         head_id,
    output logic                head_ext,
    output logic                head_rtr,
    output logic                head_esi,
    output logic [3:0]          head_dlc,
    output logic                evt_new,
    output logic                evt_wmark,
    output logic                evt_lost
);
    import rxq_pkg::*;

    localparam int IDX_W    = $clog2(DEPTH);
    localparam int CNT_W    = IDX_W + 1;
    localparam int ELEM_SH  = $clog2(ELEM_WORDS * 4);

    logic [CF_FIELD_W-1:0] size_raw, wm_raw;
    logic [CNT_W-1:0]      size_eff, wmark, fill, fill_nxt;
    logic [IDX_W-1:0]      put_idx, get_idx;
    logic                  full, lost, store, drop;
    logic [WORD_W-1:0]     hw0, hw1;
    logic [ADDR_W-1:0]     base;
    logic                  unused_cfg;

    assign size_raw   = cfg_word[CF_SIZE_LSB +: CF_FIELD_W];
    assign wm_raw     = cfg_word[CF_WM_LSB   +: CF_FIELD_W];
    assign base       = cfg_word[CF_BASE_LSB +: ADDR_W];
    assign unused_cfg = ^{cfg_word[31], cfg_word[23]};

    // Clamp the configured length to the physical depth.
    always_comb begin
        if (32'(size_raw) > DEPTH) size_eff = CNT_W'(DEPTH);
        else                       size_eff = CNT_W'(size_raw);
        wmark = CNT_W'(wm_raw);
    end

    rxq_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .size(size_eff), .wr_valid(wr_valid),
        .ack_valid(ack_valid), .ack_idx(ack_idx[IDX_W-1:0]), .lost_clr(lost_clr),
        .put_idx(put_idx), .get_idx(get_idx), .fill(fill), .fill_nxt(fill_nxt),
        .full(full), .lost(lost), .store(store), .drop(drop)
    );

    rxq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W),
                .WORDS(ELEM_WORDS), .SEL_W(2)) u_store (
        .clk(clk), .store(store), .put_idx(put_idx), .elem(wr_elem),
        .rd_idx(rd_idx[IDX_W-1:0]), .rd_sel(rd_sel), .head_idx(get_idx),
        .rd_data(rd_data), .head_w0(hw0), .head_w1(hw1)
    );

    rxq_events #(.CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .store(store), .drop(drop),
        .fill_nxt(fill_nxt), .wmark(wmark),
        .evt_new(evt_new), .evt_wmark(evt_wmark), .evt_lost(evt_lost)
    );

    // Pack the status word from the control state.
    always_comb begin
        status = '0;
        status[ST_FILL_LSB +: CNT_W] = fill;
        status[ST_GET_LSB  +: IDX_W] = get_idx;
        status[ST_PUT_LSB  +: IDX_W] = put_idx;
        status[ST_FULL_BIT]          = full;
        status[ST_LOST_BIT]          = lost;
    end

    // Decode the oldest element and compute its byte address.
    always_comb begin
        head_valid = (fill != '0);
        head_addr  = base + (ADDR_W'(get_idx) << ELEM_SH);
        head_esi   = hw0[W0_ESI_BIT];
        head_ext   = hw0[W0_EXT_BIT];
        head_rtr   = hw0[W0_RTR_BIT];
        head_dlc   = hw1[W1_DLC_LSB +: DLC_W];
        if (head_ext) head_id = hw0[EXT_ID_W-1:0];
        else          head_id = EXT_ID_W'(hw0[W0_STD_LSB +: STD_ID_W]);
    end

    logic unused_hw1;
    assign unused_hw1 = ^{hw1[31:20], hw1[15:0]};

    AST_STORE_PULSES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !full && size_eff != '0) |=> evt_new);            // R2
    AST_DROP_PULSES_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full) |=> (evt_lost && status[ST_LOST_BIT]));      // R4
    AST_ZERO_SIZE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (size_eff == '0) |-> (status == 32'h0));                        // R9
endmodule

// File: tb/rx_elem_fifo_test.sv
`timescale 1ns/10ps
module rx_elem_fifo_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cfg_word = '0;
    logic         wr_valid = 1'b0;
    logic [127:0] wr_elem = '0;
    logic         ack_valid = 1'b0;
    logic [5:0]   ack_idx = '0;
    logic         lost_clr = 1'b0;
    logic [5:0]   rd_idx = '0;
    logic [1:0]   rd_sel = '0;
    logic [31:0]  rd_data, status;
    logic         head_valid, head_ext, head_rtr, head_esi;
    logic [15:0]  head_addr;
    logic [28:0]  head_id;
    logic [3:0]   head_dlc;
    logic         evt_new, evt_wmark, evt_lost;

    rx_elem_fifo uut (.*);

    always #5 clk = ~clk;

    int errors = 0, checks = 0;
    int m_size, m_wm, m_base, m_put, m_get, m_fill;
    bit m_lost;
    logic [127:0] sb[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_std(input logic [10:0] id, input logic [3:0] dlc,
                                            input bit esi, input logic [63:0] data);
        return {data, 12'h0, dlc, 16'h0, esi, 2'b00, id, 18'h0};
    endfunction

    function automatic logic [127:0] mk_ext(input logic [28:0] id, input bit rtr,
                                            input logic [3:0] dlc, input logic [63:0] data);
        return {data, 12'h0, dlc, 16'h0, 1'b0, 1'b1, rtr, id};
    endfunction

    function automatic logic [31:0] exp_status();
        return {6'h0, m_lost, (m_size != 0 && m_fill == m_size), 2'b0, 6'(m_put),
                2'b0, 6'(m_get), 1'b0, 7'(m_fill)};
    endfunction

    task automatic do_reset(input int size_f, input int wm, input int base);
        rst_n = 1'b0;
        cfg_word = {1'b0, 7'(wm), 1'b0, 7'(size_f), 16'(base)};
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        m_size = (size_f > 64) ? 64 : size_f;
        m_wm = wm; m_base = base;
        m_put = 0; m_get = 0; m_fill = 0; m_lost = 0;
        sb.delete();
    endtask

    // Driver: one cycle of stimulus; pushes accepted elements onto the
    // scoreboard and, before an in-range acknowledge, acts as monitor by
    // reading back each freed element and comparing it with the popped entry.
    task automatic step(input bit wv, input logic [127:0] el, input bit av,
                        input int ai, input bit clr);
        bit st, dr, aok, wm;
        int off;
        st = wv && m_size != 0 && m_fill < m_size;
        dr = wv && m_size != 0 && m_fill >= m_size;
        off = (m_size != 0) ? ((ai - m_get + m_size) % m_size) : 0;
        aok = av && m_size != 0 && ai < m_size && off < m_fill;
        if (aok) begin
            for (int i = 0; i <= off; i++) begin
                logic [127:0] e;
                e = sb.pop_front();
                rd_idx = 6'((m_get + i) % m_size);
                for (int w = 0; w < 4; w++) begin
                    rd_sel = 2'(w);
                    #0.1;
                    chk(rd_data == e[w*32 +: 32], "R11", 64'(rd_data), 64'(e[w*32 +: 32]),
                        "scoreboard word");
                end
            end
        end
        wr_valid = wv; wr_elem = el; ack_valid = av; ack_idx = 6'(ai); lost_clr = clr;
        @(posedge clk);
        #2;
        wr_valid = 1'b0; ack_valid = 1'b0; lost_clr = 1'b0;
        if (aok) begin
            m_get = (ai + 1) % m_size;
            m_fill = m_fill - (off + 1);
        end
        if (st) begin
            sb.push_back(el);
            m_put = (m_put + 1) % m_size;
            m_fill++;
        end
        wm = st && m_wm != 0 && m_fill == m_wm;
        if (dr) m_lost = 1'b1;
        else if (clr) m_lost = 1'b0;
        chk(status == exp_status(), "R3", 64'(status), 64'(exp_status()), "status");
        chk(evt_new == st, "R2", 64'(evt_new), 64'(st), "evt_new");
        chk(evt_lost == dr, "R4", 64'(evt_lost), 64'(dr), "evt_lost");
        chk(evt_wmark == wm, "R8", 64'(evt_wmark), 64'(wm), "evt_wmark");
        chk(head_addr == 16'(m_base + 16 * m_get), "R9", 64'(head_addr),
            64'(16'(m_base + 16 * m_get)), "head_addr");
    endtask

    task automatic chk_head(input logic [28:0] id, input bit ext, input bit rtr,
                            input bit esi, input logic [3:0] dlc);
        chk(head_valid == 1'b1, "R10", 64'(head_valid), 64'd1, "head_valid");
        chk(head_id == id, "R10", 64'(head_id), 64'(id), "head_id");
        chk({head_ext, head_rtr, head_esi} == {ext, rtr, esi}, "R10",
            64'({head_ext, head_rtr, head_esi}), 64'({ext, rtr, esi}), "flags");
        chk(head_dlc == dlc, "R10", 64'(head_dlc), 64'(dlc), "head_dlc");
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] ea, eb, ec, ed;
        ea = mk_std(11'h123, 4'd8, 1'b0, 64'h0011223344556677);
        eb = mk_ext(29'h12345678, 1'b1, 4'd0, 64'h0);
        ec = mk_std(11'h7FF, 4'd3, 1'b1, 64'hA5A5A5A5_5A5A5A5A);
        ed = mk_std(11'h001, 4'd1, 1'b0, 64'hFF);

        // R1: reset state
        do_reset(4, 3, 16'h0100);
        @(negedge clk);
        chk(status == 32'h0, "R1", 64'(status), 64'h0, "status after reset");
        chk({evt_new, evt_wmark, evt_lost, head_valid} == 4'b0, "R1",
            64'({evt_new, evt_wmark, evt_lost, head_valid}), 64'h0, "outputs after reset");
        @(posedge clk); #2;

        // R2 R8 R10: fill to watermark, decode a standard head
        step(1, ea, 0, 0, 0);
        chk_head(29'h123, 0, 0, 0, 4'd8);
        step(1, eb, 0, 0, 0);
        step(1, ec, 0, 0, 0);
        // R4: fill to full, then drop
        step(1, ed, 0, 0, 0);
        step(1, mk_std(11'h055, 4'd2, 0, 64'h1), 0, 0, 0);
        // R11: direct read of element 2
        for (int w = 0; w < 4; w++) begin
            rd_idx = 6'd2; rd_sel = 2'(w); #0.1;
            chk(rd_data == ec[w*32 +: 32], "R11", 64'(rd_data), 64'(ec[w*32 +: 32]), "rd word");
        end
        // R7: ack index beyond length is ignored
        step(0, '0, 1, 5, 0);
        // R6: ack frees elements 0 and 1
        step(0, '0, 1, 1, 0);
        chk_head(29'h7FF, 0, 0, 1, 4'd3);
        // R7: stale index outside filled span is ignored
        step(0, '0, 1, 1, 0);
        // R5: refill to full, drop with clear keeps flag, clear alone resets it
        step(1, mk_ext(29'h1ABCDEF, 0, 4'd6, 64'h77), 0, 0, 0);
        step(1, mk_ext(29'h0000042, 0, 4'd7, 64'h88), 0, 0, 0);
        step(1, ea, 0, 0, 1);
        step(0, '0, 0, 0, 1);
        // R6: ack frees elements 2 and 3 with wrap of get
        step(0, '0, 1, 3, 0);
        chk_head(29'h1ABCDEF, 1, 0, 0, 4'd6);
        // R12: ack and store in the same cycle
        step(1, ed, 1, 0, 0);
        chk_head(29'h0000042, 1, 0, 0, 4'd7);
        step(0, '0, 1, 2, 0);

        // R9: length 0 discards without loss
        do_reset(0, 1, 0);
        step(1, ea, 0, 0, 0);
        chk(evt_lost == 1'b0 && status == 32'h0, "R9", 64'(status), 64'h0, "size zero");

        // R9 R8 R4: length above 64 acts as 64; watermark at 64
        do_reset(100, 64, 16'h2000);
        for (int n = 0; n < 64; n++) step(1, mk_std(11'(n), 4'(n), 0, 64'(n)), 0, 0, 0);
        chk(status == 32'h0100_0040, "R9", 64'(status), 64'h0100_0040, "clamped full");
        step(1, ea, 0, 0, 0);
        step(0, '0, 1, 63, 0);

        // R8: watermark 0 never pulses
        do_reset(2, 0, 0);
        step(1, ea, 0, 0, 0);
        step(1, eb, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule